// File: doc/BRIEF.md
# AER Spike Frame Packer

This block sits between a local spiking neural fabric and a UDP transmitter. Every clock cycle it may receive one spike, given as a neuron number. It thins the stream so that only every n-th spike survives. Each surviving spike becomes a 32-bit address-event word made of a device identifier, two zero pad bits and the neuron number. Surviving spikes that arrive back to back are packed into one frame payload, and that payload is streamed out as bytes with start and end markers.

A frame is never held back to grow larger. It closes on the first cycle that brings no surviving spike, or when it reaches the word cap, and the spikes that remain then start a fresh frame. A word FIFO absorbs back-pressure from the byte stream. If that FIFO is full, newly arriving spikes are discarded and a sticky flag records the loss. Header building, checksums and MAC control belong to the surrounding transmitter.

Top module: `aer_frame_packer`

## Requirements
- R1: Each event word carries the device identifier in bits 31..16, zeros in bits 15..14 and the neuron number in bits 13..0, all taken from the inputs of the cycle the spike arrived in.
- R2: A word leaves as four bytes, most significant byte first. `outSof` is high only with the first byte of a frame and `outEof` only with its last byte.
- R3: Surviving spikes on consecutive cycles form one frame. The first cycle without a surviving spike closes it, so surviving spikes separated by any gap go into separate frames.
- R4: A frame holds at most MAX_WORDS words (256 by default). Further spikes of the same run start a new frame.
- R5: The downsampler passes the n-th, 2n-th, 3n-th... valid spike, where n is the loaded ratio. A ratio of 1 passes every spike, and a ratio of 0 acts as 1.
- R6: A pulse on `ratioLoad` stores `ratioIn` and restarts the count, so the next surviving spike is the n-th valid spike after the load. A spike offered in the load cycle is discarded and is not counted.
- R7: The byte output uses a valid/ready handshake. A byte moves when `outValid` and `outReady` are both high. While `outValid` is high and `outReady` is low, `outData`, `outSof` and `outEof` hold their values.
- R8: When the FIFO is full, a newly surviving spike is dropped and the word already staged is kept. `overflow` then goes high and stays high until reset.
- R9: After reset `outValid` and `overflow` are low and the ratio is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| spikeValid | input | 1 | A spike is present this cycle |
| spikeNeuron | input | 14 | Neuron number of the spike |
| devId | input | 16 | Device identifier placed in the upper half of each word |
| ratioIn | input | 16 | Downsampling ratio to load |
| ratioLoad | input | 1 | Single-cycle strobe that loads `ratioIn` |
| outData | output | 8 | Payload byte |
| outValid | output | 1 | Payload byte available |
| outReady | input | 1 | Transmitter accepts the byte |
| outSof | output | 1 | Byte is the first of a frame |
| outEof | output | 1 | Byte is the last of a frame |
| overflow | output | 1 | Sticky flag: at least one spike was dropped |

## Verification
The assertions assume that `spikeNeuron` and `devId` are valid whenever `spikeValid` is high, that `ratioLoad` is a single-cycle pulse, and that `outReady` may change freely. The handshake-hold property relies on the transmitter never seeing a byte withdrawn. The bench applies a fresh reset before each scenario and drives every input just after the rising edge with defined values. It stalls the output either by holding `outReady` low or by toggling it every cycle, which exercises both the hold rule and the FIFO-full path.

// File: rtl/aer_pack_pkg.sv
package aer_pack_pkg;

  localparam int AER_WORD_W = 32;
  localparam int AER_ID_W   = 16;
  localparam int AER_NRN_W  = 14;
  localparam int AER_PAD_W  = AER_WORD_W - AER_ID_W - AER_NRN_W;
  localparam int AER_BYTES  = AER_WORD_W / 8;

  typedef logic [AER_WORD_W-1:0] aer_word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStage;   // capture the new event word into the stage register
    logic pushStage;   // write the staged word into the FIFO
    logic pushLast;    // the pushed word ends its frame
    logic dropSpike;   // a surviving spike is discarded because the FIFO is full
  } pack_strobe_t;

endpackage

// File: rtl/aer_pack_ctrl.sv
module aer_pack_ctrl
  import aer_pack_pkg::*;
#(
  parameter int MAX_WORDS = 256,
  parameter int RATIO_W   = 16,
  parameter int DEF_RATIO = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               spikeValid,
  input  logic [RATIO_W-1:0] ratioIn,
  input  logic               ratioLoad,
  input  logic               fifoFull,
  output pack_strobe_t       strobe
);

  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(DEF_RATIO);

  function automatic logic [RATIO_W-1:0] effRatio(input logic [RATIO_W-1:0] r);
    return (r == '0) ? RATIO_W'(1) : r;
  endfunction

  logic [RATIO_W-1:0] ratioReg;
  logic [RATIO_W-1:0] dsCnt;
  logic               keep;
  logic               stgValid;
  logic               stgClose;
  logic [CNT_W-1:0]   frameCnt;
  logic               stgLast;

  // downsampler: counts valid spikes down, passes the one that reaches 1
  assign keep = spikeValid && !ratioLoad && (dsCnt <= RATIO_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioReg <= RESET_RATIO;
      dsCnt    <= effRatio(RESET_RATIO);
    end else if (ratioLoad) begin
      ratioReg <= ratioIn;
      dsCnt    <= effRatio(ratioIn);
    end else if (spikeValid) begin
      dsCnt <= (dsCnt <= RATIO_W'(1)) ? effRatio(ratioReg) : dsCnt - RATIO_W'(1);
    end
  end

  // staged word ends its frame if its run has closed or the cap is reached
  assign stgLast = stgClose || (frameCnt == CNT_W'(MAX_WORDS));

  always_comb begin
    strobe = '0;
    if (keep) begin
      if (stgValid) begin
        if (!fifoFull) begin
          strobe.pushStage = 1'b1;
          strobe.pushLast  = stgLast;
          strobe.loadStage = 1'b1;
        end else begin
          strobe.dropSpike = 1'b1;
        end
      end else begin
        strobe.loadStage = 1'b1;
      end
    end else if (stgValid && !fifoFull) begin
      strobe.pushStage = 1'b1;
      strobe.pushLast  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgValid <= 1'b0;
      stgClose <= 1'b0;
      frameCnt <= '0;
    end else if (keep) begin
      if (stgValid) begin
        if (!fifoFull) begin
          frameCnt <= stgLast ? CNT_W'(1) : frameCnt + CNT_W'(1);
          stgClose <= 1'b0;
        end
      end else begin
        stgValid <= 1'b1;
        stgClose <= 1'b0;
        frameCnt <= CNT_W'(1);
      end
    end else if (stgValid) begin
      if (!fifoFull) begin
        stgValid <= 1'b0;
        stgClose <= 1'b0;
      end else begin
        stgClose <= 1'b1;
      end
    end
  end

  AST_FRAME_CAP: assert property (@(posedge clk) disable iff (!rstN)
    stgValid |-> (frameCnt >= CNT_W'(1) && frameCnt <= CNT_W'(MAX_WORDS))); // R4

  AST_LOAD_NEEDS_SPIKE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadStage || strobe.dropSpike) |-> (spikeValid && !ratioLoad)); // R6

  AST_UNIT_RATIO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (effRatio(ratioReg) == RATIO_W'(1) && spikeValid && !ratioLoad)
      |-> (strobe.loadStage || strobe.dropSpike)); // R5

  AST_GAP_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushStage && !keep) |-> strobe.pushLast); // R3

endmodule

// File: rtl/aer_pack_datapath.sv
module aer_pack_datapath
  import aer_pack_pkg::*;
#(
  parameter int FIFO_DEPTH = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pack_strobe_t         strobe,
  input  logic [AER_ID_W-1:0]  devId,
  input  logic [AER_NRN_W-1:0] spikeNeuron,
  output logic                 fifoFull,
  output logic [7:0]           outData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic                 outSof,
  output logic                 outEof,
  output logic                 overflow
);

  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int BIDX_W = $clog2(AER_BYTES);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  typedef struct packed {
    logic      last;
    aer_word_t word;
  } fifo_entry_t;

  aer_word_t     stgWord;
  fifo_entry_t   mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W:0]   fill;
  fifo_entry_t   head;
  logic [BIDX_W-1:0] byteIdx;
  logic          atFrameStart;
  logic          pop;
  logic          lastByte;

  // stage register holds the most recent surviving spike as a full event word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgWord <= '0;
    end else if (strobe.loadStage) begin
      stgWord <= {devId, {AER_PAD_W{1'b0}}, spikeNeuron};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushStage) begin
      mem[wrPtr] <= '{last: strobe.pushLast, word: stgWord};
    end
  end

  assign fifoFull = (fill == (PTR_W+1)'(FIFO_DEPTH));
  assign outValid = (fill != '0);
  assign head     = mem[rdPtr];
  assign lastByte = (byteIdx == BIDX_W'(AER_BYTES - 1));
  assign pop      = outValid && outReady && lastByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (strobe.pushStage) begin
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      end
      if (pop) begin
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      end
      case ({strobe.pushStage, pop})
        2'b10:   fill <= fill + (PTR_W+1)'(1);
        2'b01:   fill <= fill - (PTR_W+1)'(1);
        default: fill <= fill;
      endcase
    end
  end

  // byte serializer, most significant byte first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx      <= '0;
      atFrameStart <= 1'b1;
    end else if (outValid && outReady) begin
      byteIdx <= lastByte ? '0 : byteIdx + BIDX_W'(1);
      if (lastByte) begin
        atFrameStart <= head.last;
      end
    end
  end

  always_comb begin
    outData = '0;
    for (int b = 0; b < AER_BYTES; b++) begin
      if (byteIdx == BIDX_W'(b)) begin
        outData = head.word[(AER_BYTES-1-b)*8 +: 8];
      end
    end
  end

  assign outSof = outValid && atFrameStart && (byteIdx == '0);
  assign outEof = outValid && head.last && lastByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= 1'b0;
    end else if (strobe.dropSpike) begin
      overflow <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushStage |-> !fifoFull); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      (outValid && $stable(outData) && $stable(outSof) && $stable(outEof))); // R7

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fill <= (PTR_W+1)'(FIFO_DEPTH)); // R8

endmodule

// File: rtl/aer_frame_packer.sv
module aer_frame_packer
  import aer_pack_pkg::*;
#(
  parameter int MAX_WORDS  = 256,
  parameter int FIFO_DEPTH = 256,
  parameter int RATIO_W    = 16,
  parameter int DEF_RATIO  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 spikeValid,
  input  logic [AER_NRN_W-1:0] spikeNeuron,
  input  logic [AER_ID_W-1:0]  devId,
  input  logic [RATIO_W-1:0]   ratioIn,
  input  logic                 ratioLoad,
  output logic [7:0]           outData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic                 outSof,
  output logic                 outEof,
  output logic                 overflow
);

  pack_strobe_t strobe;
  logic         fifoFull;

  aer_pack_ctrl #(
    .MAX_WORDS (MAX_WORDS),
    .RATIO_W   (RATIO_W),
    .DEF_RATIO (DEF_RATIO)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .spikeValid (spikeValid),
    .ratioIn    (ratioIn),
    .ratioLoad  (ratioLoad),
    .fifoFull   (fifoFull),
    .strobe     (strobe)
  );

  aer_pack_datapath #(
    .FIFO_DEPTH (FIFO_DEPTH)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .devId       (devId),
    .spikeNeuron (spikeNeuron),
    .fifoFull    (fifoFull),
    .outData     (outData),
    .outValid    (outValid),
    .outReady    (outReady),
    .outSof      (outSof),
    .outEof      (outEof),
    .overflow    (overflow)
  );

endmodule

// File: tb/test_aer_frame_packer.sv
`timescale 1ns/1ps
module test_aer_frame_packer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        spikeValid;
  logic [13:0] spikeNeuron;
  logic [15:0] devId;
  logic [15:0] ratioIn;
  logic        ratioLoad;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady;
  logic        outSof;
  logic        outEof;
  logic        overflow;

  int checks = 0;
  int failures = 0;
  bit readyLevel = 1'b1;
  bit toggleMode = 1'b0;
  int stallErrs = 0;

  logic [7:0] rxData[$];
  bit         rxSof[$];
  bit         rxEof[$];
  logic [7:0] expData[$];
  bit         expSof[$];
  bit         expEof[$];

  always #2.5 clk = ~clk;

  aer_frame_packer i_aer_frame_packer (
    .clk(clk), .rstN(rstN), .spikeValid(spikeValid), .spikeNeuron(spikeNeuron),
    .devId(devId), .ratioIn(ratioIn), .ratioLoad(ratioLoad),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outSof(outSof), .outEof(outEof), .overflow(overflow)
  );

  // ready driver
  initial outReady = 1'b1;
  always @(posedge clk) begin
    #1;
    if (toggleMode) outReady <= ~outReady;
    else            outReady <= readyLevel;
  end

  // monitor, away from the active edge
  logic [7:0] prevData;
  bit prevSof, prevEof, prevStall = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall && (!outValid || outData !== prevData || outSof !== prevSof || outEof !== prevEof))
        stallErrs++;
      prevStall = outValid && !outReady;
      prevData = outData; prevSof = outSof; prevEof = outEof;
      if (outValid && outReady) begin
        rxData.push_back(outData); rxSof.push_back(outSof); rxEof.push_back(outEof);
      end
    end else begin
      prevStall = 1'b0;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; spikeValid = 1'b0; spikeNeuron = '0; devId = 16'h1234;
    ratioIn = '0; ratioLoad = 1'b0; toggleMode = 1'b0; readyLevel = 1'b1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    rxData.delete(); rxSof.delete(); rxEof.delete();
    expData.delete(); expSof.delete(); expEof.delete();
  endtask

  task automatic expWord(logic [15:0] dev, logic [13:0] nrn, bit first, bit last);
    logic [31:0] w;
    w = {dev, 2'b00, nrn};
    for (int b = 3; b >= 0; b--) begin
      expData.push_back(w[b*8 +: 8]);
      expSof.push_back(first && b == 3);
      expEof.push_back(last && b == 0);
    end
  endtask

  task automatic loadRatio(logic [15:0] r);
    ratioIn = r; ratioLoad = 1'b1; tick(); ratioLoad = 1'b0;
  endtask

  task automatic spike(logic [13:0] n);
    spikeValid = 1'b1; spikeNeuron = n; tick();
  endtask

  task automatic gap();
    spikeValid = 1'b0; tick();
  endtask

  task automatic burst(int first, int count);
    for (int i = 0; i < count; i++) spike(14'(first + i));
    gap();
  endtask

  task automatic drain();
    int idle = 0;
    int guard = 0;
    while (idle < 12 && guard < 20000) begin
      tick();
      if (!outValid) idle++; else idle = 0;
      guard++;
    end
  endtask

  task automatic compareRx(string req);
    int n;
    checkEq(req, "byte count", rxData.size(), expData.size());
    n = (rxData.size() < expData.size()) ? rxData.size() : expData.size();
    for (int i = 0; i < n; i++) begin
      checkEq(req, $sformatf("byte %0d data", i), rxData[i], expData[i]);
      checkEq(req, $sformatf("byte %0d sof", i), rxSof[i], expSof[i]);
      checkEq(req, $sformatf("byte %0d eof", i), rxEof[i], expEof[i]);
    end
  endtask

  // R9: reset state and default ratio of 1
  task automatic tReset();
    doReset();
    checkEq("R9", "outValid after reset", outValid, 0);
    checkEq("R9", "overflow after reset", overflow, 0);
    checkEq("R9", "outSof after reset", outSof, 0);
    spike(5); gap(); spike(6); gap();
    drain();
    expWord(16'h1234, 5, 1, 1);
    expWord(16'h1234, 6, 1, 1);
    compareRx("R9");
  endtask

  // R1, R2: word layout and byte order
  task automatic tFormat();
    doReset();
    devId = 16'hABCD; spike(14'h3FFF);
    devId = 16'h0001; gap();
    spike(14'h2000); gap();
    drain();
    expWord(16'hABCD, 14'h3FFF, 1, 1);
    expWord(16'h0001, 14'h2000, 1, 1);
    compareRx("R1");
    checkEq("R2", "first byte is MSB", rxData.size() > 0 ? rxData[0] : 8'h0, 8'hAB);
  endtask

  // R3: runs of consecutive spikes form frames
  task automatic tGroup();
    doReset();
    burst(10, 3);
    burst(20, 2);
    drain();
    expWord(16'h1234, 10, 1, 0); expWord(16'h1234, 11, 0, 0); expWord(16'h1234, 12, 0, 1);
    expWord(16'h1234, 20, 1, 0); expWord(16'h1234, 21, 0, 1);
    compareRx("R3");
  endtask

  // R5: downsampling
  task automatic tDownsample();
    doReset();
    loadRatio(3);
    for (int i = 1; i <= 7; i++) begin spike(14'(i)); gap(); end
    drain();
    expWord(16'h1234, 3, 1, 1); expWord(16'h1234, 6, 1, 1);
    compareRx("R5 ratio3");

    doReset();
    loadRatio(2);
    burst(1, 6);
    drain();
    expWord(16'h1234, 2, 1, 1); expWord(16'h1234, 4, 1, 1); expWord(16'h1234, 6, 1, 1);
    compareRx("R5 R3 ratio2 run");

    doReset();
    loadRatio(0);
    burst(40, 2);
    drain();
    expWord(16'h1234, 40, 1, 0); expWord(16'h1234, 41, 0, 1);
    compareRx("R5 ratio0");
  endtask

  // R6: reload restarts the count, load-cycle spike discarded
  task automatic tReload();
    doReset();
    loadRatio(4);
    spike(1); gap(); spike(2); gap();
    ratioIn = 3; ratioLoad = 1'b1; spikeValid = 1'b1; spikeNeuron = 99; tick();
    ratioLoad = 1'b0; gap();
    for (int i = 3; i <= 5; i++) begin spike(14'(i)); gap(); end
    drain();
    expWord(16'h1234, 5, 1, 1);
    compareRx("R6");
  endtask

  // R4: cap of 256 words
  task automatic tCap();
    doReset();
    burst(1, 260);
    drain();
    for (int i = 1; i <= 256; i++) expWord(16'h1234, 14'(i), i == 1, i == 256);
    for (int i = 257; i <= 260; i++) expWord(16'h1234, 14'(i), i == 257, i == 260);
    compareRx("R4");
    checkEq("R4", "no overflow", overflow, 0);
  endtask

  // R7: toggling ready, bytes held while stalled
  task automatic tBackpressure();
    doReset();
    stallErrs = 0;
    toggleMode = 1'b1;
    burst(100, 3);
    drain();
    toggleMode = 1'b0;
    tick();
    expWord(16'h1234, 100, 1, 0); expWord(16'h1234, 101, 0, 0); expWord(16'h1234, 102, 0, 1);
    compareRx("R7");
    checkEq("R7", "stall hold violations", stallErrs, 0);
  endtask

  // R8: FIFO full drops spikes, flag sticky
  task automatic tOverflow();
    doReset();
    readyLevel = 1'b0;
    tick();
    burst(1, 300);
    checkEq("R8", "overflow set", overflow, 1);
    checkEq("R8", "output pending", outValid, 1);
    readyLevel = 1'b1;
    drain();
    for (int i = 1; i <= 256; i++) expWord(16'h1234, 14'(i), i == 1, i == 256);
    expWord(16'h1234, 257, 1, 1);
    compareRx("R8");
    checkEq("R8", "overflow sticky", overflow, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tReset();
    tFormat();
    tGroup();
    tDownsample();
    tReload();
    tCap();
    tBackpressure();
    tOverflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule